// File: doc/BRIEF.md
# Wormhole Round-Robin Switch Allocator

This block is the third stage of a packet router that uses virtual output queues (VOQs). Every input keeps a separate queue for each output, and the route has already been computed by the time a flit reaches this stage. For each output the allocator looks at the inputs whose queue for that output holds a flit. It picks one of them in round-robin order and drives the crossbar select for that output. It also pops the winning queue whenever the downstream side acknowledges.

Packets are never interleaved on an output. The first flit of a packet takes ownership of the output for its input. Ownership lasts until the flit that carries the end-of-packet mark has been transferred. During that time other inputs get nothing from that output, and the round-robin pointer moves past the winner only when the packet ends. Each output is arbitrated independently, so one input can stream to several outputs in the same cycle.

Top module: `swa_top`

## Requirements
- R1: After synchronous reset no output is owned and every round-robin pointer is 0. With no request there is no pop and no valid output. The first unowned arbitration on any output favours input 0.
- R2: A pop is raised only for a (input, output) pair whose request is high. On each output at most one input is popped per cycle. Lane index k = i*N_OUT + o addresses input i, output o in req_i, eop_i and pop_o.
- R3: When out_rdy_i[o] is low, output o moves no flit: out_val_o[o] is 0 and no input is popped for o.
- R4: On an unowned output, the winner is the first requesting input found by scanning upward from the pointer and wrapping from N_IN-1 to 0.
- R5: A flit transferred with its eop bit low gives the output to that input. held_o[o] is high from the next cycle, and out_sel_o holds that input.
- R6: While an output is owned, only the owner can move a flit on it. Requests from other inputs to that output are ignored. If the owner has no flit, the output idles.
- R7: A flit transferred with its eop bit high releases the output from the next cycle. The pointer becomes winner+1, wrapping to 0. A packet of one flit never takes ownership.
- R8: Outputs are independent. One input may be popped on several outputs in the same cycle.
- R9: out_val_o[o] is high exactly when a flit moves on output o. When it is high, field o of out_sel_o (bits o*SEL_W upward) holds the index of the popped input.
- R10: The pointer does not move on a stalled cycle or on a transfer without eop. Once the output is released, the rotation resumes from where it stood.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_IN*N_OUT | VOQ non-empty flags, lane i*N_OUT+o |
| eop_i | input | N_IN*N_OUT | Head flit of that VOQ ends its packet |
| out_rdy_i | input | N_OUT | Downstream acknowledge per output |
| pop_o | output | N_IN*N_OUT | Flit leaves VOQ (i,o) this cycle |
| out_val_o | output | N_OUT | A flit is presented on output o |
| out_sel_o | output | N_OUT*SEL_W | Crossbar select per output |
| held_o | output | N_OUT | Output is owned by a packet in flight |

## Verification
A corrupted owner register shows up in the very next cycle on an owned output: out_sel_o changes, or a pop reaches a different input. A stale owned flag shows up on held_o the cycle after the tail flit has moved. A pointer that advances when it should not cannot be seen until the next unowned arbitration on that output, and only if several inputs are requesting at that moment. For that reason the stimulus keeps several inputs contending across packet boundaries, and the reference model checks every output on every cycle.

// File: rtl/swa_pkg.sv
package swa_pkg;

    typedef enum logic {
        OWN_FREE = 1'b0,
        OWN_HELD = 1'b1
    } own_e;

    // Next round-robin start after a winner, wrapping at n.
    function automatic int unsigned rr_after(int unsigned idx, int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/swa_rr_pick.sv
module swa_rr_pick #(
    parameter int unsigned N = 5,
    parameter int unsigned W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] base,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        int unsigned p;
        any = 1'b0;
        idx = '0;
        for (int unsigned k = 0; k < N; k++) begin
            p = 32'(base) + k;
            if (p >= N) p = p - N;
            if (!any && req[p]) begin
                any = 1'b1;
                idx = W'(p);
            end
        end
    end
endmodule

// File: rtl/swa_out_ctl.sv
module swa_out_ctl
    import swa_pkg::*;
#(
    parameter int unsigned N_IN  = 5,
    parameter int unsigned SEL_W = $clog2(N_IN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_IN-1:0]    req,
    input  logic [N_IN-1:0]    eop,
    input  logic               rdy,
    output logic [N_IN-1:0]    pop,
    output logic               val,
    output logic [SEL_W-1:0]   sel,
    output logic               held
);
    own_e             state_q;
    logic [SEL_W-1:0] owner_q;
    logic [SEL_W-1:0] ptr_q;

    logic             pick_any;
    logic [SEL_W-1:0] pick_idx;
    logic [SEL_W-1:0] cand;
    logic             cand_v;

    swa_rr_pick #(.N(N_IN), .W(SEL_W)) u_pick (
        .req  (req),
        .base (ptr_q),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    always_comb begin
        if (state_q == OWN_HELD) begin
            cand   = owner_q;
            cand_v = req[owner_q];
        end else begin
            cand   = pick_idx;
            cand_v = pick_any;
        end
        val = cand_v & rdy;
        pop = '0;
        if (val) pop[cand] = 1'b1;
    end

    assign sel  = cand;
    assign held = (state_q == OWN_HELD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OWN_FREE;
            owner_q <= '0;
            ptr_q   <= '0;
        end else if (val) begin
            if (eop[cand]) begin
                state_q <= OWN_FREE;
                ptr_q   <= SEL_W'(rr_after(32'(cand), N_IN));
            end else begin
                state_q <= OWN_HELD;
                owner_q <= cand;
            end
        end
    end
endmodule

// File: rtl/swa_top.sv
module swa_top #(
    parameter int unsigned N_IN  = 5,
    parameter int unsigned N_OUT = 5,
    localparam int unsigned SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int unsigned LANES = N_IN * N_OUT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES-1:0]       req_i,
    input  logic [LANES-1:0]       eop_i,
    input  logic [N_OUT-1:0]       out_rdy_i,
    output logic [LANES-1:0]       pop_o,
    output logic [N_OUT-1:0]       out_val_o,
    output logic [N_OUT*SEL_W-1:0] out_sel_o,
    output logic [N_OUT-1:0]       held_o
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [N_IN-1:0] req_col;
        logic [N_IN-1:0] eop_col;
        logic [N_IN-1:0] pop_col;

        for (genvar i = 0; i < N_IN; i++) begin : g_lane
            assign req_col[i]           = req_i[i*N_OUT + o];
            assign eop_col[i]           = eop_i[i*N_OUT + o];
            assign pop_o[i*N_OUT + o]   = pop_col[i];
        end

        swa_out_ctl #(.N_IN(N_IN), .SEL_W(SEL_W)) u_ctl (
            .clk  (clk),
            .rst  (rst),
            .req  (req_col),
            .eop  (eop_col),
            .rdy  (out_rdy_i[o]),
            .pop  (pop_col),
            .val  (out_val_o[o]),
            .sel  (out_sel_o[o*SEL_W +: SEL_W]),
            .held (held_o[o])
        );
    end
endmodule

// File: rtl/swa_chk.sv
module swa_chk #(
    parameter int unsigned N_IN  = 5,
    parameter int unsigned N_OUT = 5,
    parameter int unsigned SEL_W = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic [N_IN*N_OUT-1:0]  req_i,
    input logic [N_IN*N_OUT-1:0]  eop_i,
    input logic [N_OUT-1:0]       out_rdy_i,
    input logic [N_IN*N_OUT-1:0]  pop_o,
    input logic [N_OUT-1:0]       out_val_o,
    input logic [N_OUT*SEL_W-1:0] out_sel_o,
    input logic [N_OUT-1:0]       held_o
);
    a_r2_pop_needs_req: assert property (@(posedge clk) disable iff (rst)
        (pop_o & ~req_i) == '0);

    for (genvar o = 0; o < N_OUT; o++) begin : g_o
        logic [N_IN-1:0] pcol;
        for (genvar i = 0; i < N_IN; i++) begin : g_c
            assign pcol[i] = pop_o[i*N_OUT + o];
        end

        a_r2_single_pop: assert property (@(posedge clk) disable iff (rst)
            $onehot0(pcol));

        a_r3_blocked_no_pop: assert property (@(posedge clk) disable iff (rst)
            !out_rdy_i[o] |-> (pcol == '0 && !out_val_o[o]));

        a_r9_val_tracks_pop: assert property (@(posedge clk) disable iff (rst)
            out_val_o[o] == (pcol != '0));

        a_r6_owner_fixed: assert property (@(posedge clk) disable iff (rst)
            (held_o[o] && $past(held_o[o])) |-> $stable(out_sel_o[o*SEL_W +: SEL_W]));

        for (genvar i = 0; i < N_IN; i++) begin : g_i
            a_r5_lock_on_body: assert property (@(posedge clk) disable iff (rst)
                (pop_o[i*N_OUT + o] && !eop_i[i*N_OUT + o]) |=>
                (held_o[o] && out_sel_o[o*SEL_W +: SEL_W] == SEL_W'(i)));

            a_r7_free_on_tail: assert property (@(posedge clk) disable iff (rst)
                (pop_o[i*N_OUT + o] && eop_i[i*N_OUT + o]) |=> !held_o[o]);
        end
    end
endmodule

bind swa_top swa_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .eop_i     (eop_i),
    .out_rdy_i (out_rdy_i),
    .pop_o     (pop_o),
    .out_val_o (out_val_o),
    .out_sel_o (out_sel_o),
    .held_o    (held_o)
);

// File: tb/sim_swa_top.sv
`timescale 1ns/1ps
module sim_swa_top;
    localparam int NI = 5;
    localparam int NO = 5;
    localparam int SW = $clog2(NI);
    localparam int LN = NI * NO;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [LN-1:0] req = '0;
    logic [LN-1:0] eop = '0;
    logic [NO-1:0] rdy = '0;
    logic [LN-1:0] pop;
    logic [NO-1:0] oval;
    logic [NO*SW-1:0] osel;
    logic [NO-1:0] held;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_held [NO];
    int m_own  [NO];
    int m_ptr  [NO];

    always #5 clk = ~clk;

    swa_top #(.N_IN(NI), .N_OUT(NO)) u0 (
        .clk(clk), .rst(rst), .req_i(req), .eop_i(eop), .out_rdy_i(rdy),
        .pop_o(pop), .out_val_o(oval), .out_sel_o(osel), .held_o(held)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int o = 0; o < NO; o++) begin
            m_held[o] = 0; m_own[o] = 0; m_ptr[o] = 0;
        end
    endtask

    // Compare every output against the model, then advance the model.
    task automatic cyc(input string tag);
        #1;
        for (int o = 0; o < NO; o++) begin
            int cand = 0;
            int cv = 0;
            int ev;
            if (m_held[o] != 0) begin
                cand = m_own[o];
                cv = req[cand*NO + o];
            end else begin
                for (int k = 0; k < NI; k++) begin
                    int p = (m_ptr[o] + k) % NI;
                    if (cv == 0 && req[p*NO + o]) begin
                        cv = 1; cand = p;
                    end
                end
            end
            ev = cv & rdy[o];
            chk(tag, $sformatf("held[%0d]", o), held[o], m_held[o]);
            chk(tag, $sformatf("val[%0d]", o), oval[o], ev);
            for (int i = 0; i < NI; i++)
                chk(tag, $sformatf("pop[i%0d,o%0d]", i, o), pop[i*NO + o],
                    (ev != 0 && i == cand) ? 1 : 0);
            if (ev != 0) begin
                chk(tag, $sformatf("sel[%0d]", o), int'(osel[o*SW +: SW]), cand);
                if (eop[cand*NO + o]) begin
                    m_held[o] = 0;
                    m_ptr[o] = (cand + 1) % NI;
                end else begin
                    m_held[o] = 1;
                    m_own[o] = cand;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic setl(input int i, input int o, input bit r, input bit e);
        req[i*NO + o] = r;
        eop[i*NO + o] = e;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rdy = '1;

        // R1: idle after reset, then input 0 wins first
        cyc("R1");
        for (int i = 0; i < NI; i++) setl(i, 0, 1, 1);
        cyc("R1");

        // R4/R7: single-flit packets rotate through all inputs
        repeat (NI + 2) cyc("R4");

        // R3: stalled output moves nothing
        rdy[0] = 1'b0;
        repeat (3) cyc("R3");
        rdy[0] = 1'b1;
        req = '0; eop = '0;

        // R5/R6: input 2 owns output 1 for a 4-flit packet, others contend
        setl(2, 1, 1, 0);
        cyc("R5");
        setl(0, 1, 1, 1);
        setl(3, 1, 1, 1);
        repeat (2) cyc("R6");
        setl(2, 1, 0, 0);
        cyc("R6");
        // R10: stall mid-packet, pointer stays
        setl(2, 1, 1, 0);
        rdy[1] = 1'b0;
        repeat (2) cyc("R10");
        rdy[1] = 1'b1;
        setl(2, 1, 1, 1);
        cyc("R7");
        setl(2, 1, 0, 0);
        repeat (3) cyc("R10");
        req = '0; eop = '0;

        // R8: one input streams to three outputs at once
        setl(3, 0, 1, 0);
        setl(3, 2, 1, 0);
        setl(3, 4, 1, 1);
        setl(1, 2, 1, 1);
        repeat (3) cyc("R8");
        setl(3, 0, 1, 1);
        setl(3, 2, 1, 1);
        repeat (2) cyc("R8");
        req = '0; eop = '0;
        cyc("R8");

        // R2/R9: random traffic
        for (int n = 0; n < 3000; n++) begin
            for (int k = 0; k < LN; k++) begin
                req[k] = ($urandom % 10) < 6;
                eop[k] = ($urandom % 4) == 0;
            end
            for (int o = 0; o < NO; o++) rdy[o] = ($urandom % 5) != 0;
            cyc((n % 2) ? "R2" : "R9");
        end

        // R1: reset clears ownership mid-packet
        req = '0; eop = '0;
        setl(4, 3, 1, 0);
        cyc("R5");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        req = '0;
        cyc("R1");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule